// File: doc/BRIEF.md
# Asynchronous Bus Cycle Phase Sequencer

This block runs one access on an asynchronous external memory bus at a time. It walks a fixed chain of phases: address setup, command strobe, an optional write-data hold and an optional recovery gap. Each phase lasts a programmable number of bus clock cycles. A request carries an address, a read/write flag, write data and four phase lengths. The block captures all of them when it accepts the request. It then drives chip select, an active-low read/write strobe, the data-bus output enable and the latched address and write data. On a read it captures the returned data.

The block accepts a request only while it is idle, which it shows on `req_ready`. It raises `done` for one cycle when the access and its recovery gap are over. The recovery length comes in as an input and is not chosen here. The hold phase exists only for writes. A zero hold length removes it, and chip select is then released as soon as the strobe rises.

Top module: `async_bus_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `cs_n` and `strb_n` are 1, `bus_oe` and `done` are 0, and `req_ready` is 1.
- R2: After an accept edge the address phase runs for `len_addr` cycles, with a value of 0 acting as 1. In this phase `cs_n` is 0 and `strb_n` is 1.
- R3: The command phase follows directly and lasts `len_cmd` cycles, with 0 acting as 1. In this phase `strb_n` is 0 and `cs_n` is 0. `strb_n` goes high at the end of this phase.
- R4: On a read (`req_write`=0), `rd_data` takes the value `bus_rdata` held in the last command cycle, and shows it from the next cycle. `bus_oe` stays 0 for the whole read.
- R5: On a write with `len_hold` > 0, a hold phase of `len_hold` cycles follows the command phase. In it `strb_n` is 1 while `cs_n` stays 0 and `bus_oe` stays 1. At its end `cs_n` goes to 1 and `bus_oe` to 0 together.
- R6: On a write, `bus_oe` is 1 from the first address cycle to the end of the hold phase. If `len_hold` is 0, `cs_n` and `bus_oe` are released right after the command phase. Reads never enter a hold phase, whatever `len_hold` is.
- R7: A recovery phase of `len_recov` cycles follows the access, with `cs_n`=1, `strb_n`=1 and `bus_oe`=0. A value of 0 skips it.
- R8: `done` is 1 for exactly one cycle, the first idle cycle after the last phase. `req_ready` is 1 only when idle, and that includes the `done` cycle. A request held high while busy has no effect until then.
- R9: Address, write data, write flag and phase lengths are sampled at the accept edge. Input changes during an access change neither `bus_addr`, `bus_wdata` nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| len_addr | input | CW | Address phase cycles (0 acts as 1) |
| len_cmd | input | CW | Command phase cycles (0 acts as 1) |
| len_hold | input | CW | Write hold cycles (0 skips) |
| len_recov | input | CW | Recovery cycles (0 skips) |
| bus_rdata | input | DW | Data returned by the external device |
| req_ready | output | 1 | Idle, request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| cs_n | output | 1 | Chip select, active low |
| strb_n | output | 1 | Read/write strobe, active low |
| bus_oe | output | 1 | Write data output enable |
| bus_addr | output | AW | Latched address |
| bus_wdata | output | DW | Latched write data |

## Verification
Reads and writes are run with varied phase lengths. Writes with and without a hold phase show whether chip select and the output enable are released after the command phase or after the hold phase. A read given a non-zero hold length checks that reads never hold. Zero address and command lengths check the one-cycle minimum. Zero and non-zero recovery lengths check where `done` lands. A request held high across a busy access, with its address and lengths changed mid-access, checks that it is ignored until the `done` cycle and that the running access keeps its latched values. Because `bus_rdata` changes every cycle, capturing read data one cycle off would show up as a mismatch.

// File: rtl/async_seq_pkg.sv
package async_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_CMD   = 3'd2,
    PH_HOLD  = 3'd3,
    PH_RECOV = 3'd4
  } phase_e;

  // Successor of a finished phase; zero-length optional phases are skipped.
  function automatic phase_e phase_after(phase_e p, logic is_wr,
                                         logic hold_nz, logic recov_nz);
    phase_e n;
    n = PH_IDLE;
    case (p)
      PH_ADDR:  n = PH_CMD;
      PH_CMD:   n = (is_wr && hold_nz) ? PH_HOLD : (recov_nz ? PH_RECOV : PH_IDLE);
      PH_HOLD:  n = recov_nz ? PH_RECOV : PH_IDLE;
      default:  n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/seq_pin_driver.sv
module seq_pin_driver
  import async_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e cur_phase,
  input  phase_e nxt_phase,
  input  logic   nxt_write,
  output logic   cs_n,
  output logic   strb_n,
  output logic   bus_oe,
  output logic   done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n   <= 1'b1;
      strb_n <= 1'b1;
      bus_oe <= 1'b0;
      done   <= 1'b0;
    end else begin
      cs_n   <= !(nxt_phase inside {PH_ADDR, PH_CMD, PH_HOLD});
      strb_n <= (nxt_phase != PH_CMD);
      bus_oe <= (nxt_write && (nxt_phase inside {PH_ADDR, PH_CMD})) || (nxt_phase == PH_HOLD);
      done   <= (cur_phase != PH_IDLE) && (nxt_phase == PH_IDLE);
    end
  end

  assert_strobe_inside_cs_R3: assert property (@(posedge clk) disable iff (rst)
    !strb_n |-> !cs_n);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_oe_release_with_cs_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_oe) |-> cs_n);
endmodule

// File: rtl/async_bus_seq.sv
module async_bus_seq
  import async_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] len_addr,
  input  logic [CW-1:0] len_cmd,
  input  logic [CW-1:0] len_hold,
  input  logic [CW-1:0] len_recov,
  input  logic [DW-1:0] bus_rdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          cs_n,
  output logic          strb_n,
  output logic          bus_oe,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  localparam logic [CW-1:0] ONE = CW'(1);

  phase_e        phase, nxt;
  logic          accept, load, expired;
  logic [CW-1:0] load_val;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rd_q;
  logic [CW-1:0] cmd_q, hold_q, recov_q;

  function automatic logic [CW-1:0] min1_less1(logic [CW-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  assign accept = (phase == PH_IDLE) && req_valid;

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = '0;
    if (accept) begin
      nxt      = PH_ADDR;
      load     = 1'b1;
      load_val = min1_less1(len_addr);
    end else if (phase != PH_IDLE && expired) begin
      nxt  = phase_after(phase, wr_q, hold_q != '0, recov_q != '0);
      load = 1'b1;
      case (nxt)
        PH_CMD:   load_val = min1_less1(cmd_q);
        PH_HOLD:  load_val = hold_q - ONE;
        PH_RECOV: load_val = recov_q - ONE;
        default:  load_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cmd_q   <= '0;
      hold_q  <= '0;
      recov_q <= '0;
      rd_q    <= '0;
    end else begin
      phase <= nxt;
      if (accept) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        cmd_q   <= len_cmd;
        hold_q  <= len_hold;
        recov_q <= len_recov;
      end
      if (phase == PH_CMD && expired && !wr_q)
        rd_q <= bus_rdata;
    end
  end

  seq_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  seq_pin_driver u_pins (
    .clk       (clk),
    .rst       (rst),
    .cur_phase (phase),
    .nxt_phase (nxt),
    .nxt_write (accept ? req_write : wr_q),
    .cs_n      (cs_n),
    .strb_n    (strb_n),
    .bus_oe    (bus_oe),
    .done      (done)
  );

  assign req_ready = (phase == PH_IDLE);
  assign rd_data   = rd_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  assert_hold_only_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD) |-> wr_q);
  assert_read_never_drives_R4: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !wr_q) |-> !bus_oe);
  assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(bus_addr));
  assert_recovery_released_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RECOV) |-> (cs_n && strb_n && !bus_oe));
endmodule

// File: tb/sim_async_bus_seq.sv
module sim_async_bus_seq;
  localparam int AW = 16, DW = 16, CW = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
  logic [CW-1:0] len_addr = '0, len_cmd = '0, len_hold = '0, len_recov = '0;
  logic req_ready, done, cs_n, strb_n, bus_oe;
  logic [DW-1:0] rd_data, bus_wdata;
  logic [AW-1:0] bus_addr;

  always #4 clk = ~clk;

  async_bus_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (.*);

  typedef struct {bit cs_n; bit strb_n; bit oe; bit done; bit ready; bit cap;} exp_t;
  exp_t q[$];
  exp_t cur;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [DW-1:0] exp_rd = '0, exp_wdata = '0;
  logic [AW-1:0] exp_addr = '0;

  function automatic exp_t mk(bit c, bit s, bit o, bit d, bit r, bit k);
    exp_t e;
    e.cs_n = c; e.strb_n = s; e.oe = o; e.done = d; e.ready = r; e.cap = k;
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  // Build the expected per-cycle outputs of one access from its requirements.
  task automatic plan_access();
    int a = (len_addr == 0) ? 1 : int'(len_addr);
    int c = (len_cmd == 0) ? 1 : int'(len_cmd);
    int h = req_write ? int'(len_hold) : 0;
    bit w = req_write;
    for (int i = 0; i < a; i++) q.push_back(mk(0, 1, w, 0, 0, 0));
    for (int i = 0; i < c; i++) q.push_back(mk(0, 0, w, 0, 0, (i == c - 1) && !w));
    for (int i = 0; i < h; i++) q.push_back(mk(0, 1, 1, 0, 0, 0));
    for (int i = 0; i < int'(len_recov); i++) q.push_back(mk(1, 1, 0, 0, 0, 0));
    q.push_back(mk(1, 1, 0, 1, 1, 0));
    exp_addr = req_addr;
    exp_wdata = req_wdata;
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    if (cur.cap) exp_rd = bus_rdata;
    if (cur.ready && req_valid && !rst) plan_access();
    cur = (q.size() > 0) ? q.pop_front() : mk(1, 1, 0, 0, 1, 0);
    #1;
    chk(cs_n == cur.cs_n, "R5", "cs_n", cs_n, cur.cs_n);
    chk(strb_n == cur.strb_n, "R3", "strb_n", strb_n, cur.strb_n);
    chk(bus_oe == cur.oe, "R6", "bus_oe", bus_oe, cur.oe);
    chk(done == cur.done, "R8", "done", done, cur.done);
    chk(req_ready == cur.ready, "R8", "req_ready", req_ready, cur.ready);
    chk(rd_data == exp_rd, "R4", "rd_data", rd_data, exp_rd);
    if (!cur.ready) begin
      chk(bus_addr == exp_addr, "R9", "bus_addr", bus_addr, exp_addr);
      if (bus_oe) chk(bus_wdata == exp_wdata, "R9", "bus_wdata", bus_wdata, exp_wdata);
    end
    bus_rdata = DW'(cyc * 16'h3b1 + 16'h55);
  endtask

  task automatic access(bit w, int addr, int data, int a, int c, int h, int r);
    req_write = w; req_addr = AW'(addr); req_wdata = DW'(data);
    len_addr = CW'(a); len_cmd = CW'(c); len_hold = CW'(h); len_recov = CW'(r);
    req_valid = 1;
    while (!(cur.ready && !cur.done && q.size() == 0) || !req_valid) tick();
    tick();
    req_valid = 0;
    len_addr = 4'hf; len_cmd = 4'hf; len_hold = 4'hf; len_recov = 4'hf;  // R9 mid-access changes
    req_addr = '1; req_wdata = '1;
    while (!cur.done) tick();
    tick();
  endtask

  initial begin
    cur = mk(1, 1, 0, 0, 1, 0);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(cs_n && strb_n && !bus_oe && !done && req_ready, "R1", "reset outputs",
        {cs_n, strb_n, bus_oe, done, req_ready}, 5'b11001);
    @(negedge clk); rst = 0;
    tick();
    chk(cs_n && strb_n && !bus_oe && !done && req_ready, "R1", "after reset",
        {cs_n, strb_n, bus_oe, done, req_ready}, 5'b11001);
    access(0, 16'h1200, 0, 2, 3, 0, 1);        // R2 R3 R4 read with recovery
    access(1, 16'h3400, 16'hbeef, 1, 2, 2, 0); // R5 write with hold, R7 no recovery
    access(1, 16'h5600, 16'hcafe, 3, 1, 0, 2); // R6 write without hold
    access(0, 16'h7800, 0, 0, 0, 3, 0);        // R2 R3 zero means one, R6 read ignores hold
    access(1, 16'h9a00, 16'h1234, 0, 0, 1, 3); // R7 recovery after hold
    // R8 request held high while busy: accepted only on the done cycle
    req_write = 0; req_addr = 16'hab00; len_addr = 2; len_cmd = 2; len_hold = 0; len_recov = 1;
    req_valid = 1;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (cur.ready && !cur.done) begin
        req_addr = 16'hcd00; req_write = 1; req_wdata = 16'h0f0f; len_hold = 2;
      end
    end
    req_valid = 0;
    for (int i = 0; i < 20; i++) tick();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule